// File: doc/BRIEF.md
# Per-Lane Saturating Vector Accumulator

This block holds one signed 48-bit accumulator register for each lane of a vector datapath. Each cycle that the valid strobe is high, every lane receives a 32-bit result from its lane ALU. The shared 6-bit control word selects one of several operations. The block can add the lane value into its register, subtract it from the register, or combine the register with the value and pass the sum forward without storing it. The lane value is taken as signed or unsigned. It can be aligned to the low end of the register or to its upper 32 bits. Every value the block forms is clamped to the signed 48-bit range.

Instructions may repeat over several phases. A first-phase indicator marks the first one, so the register can be cleared on entry and keep its contents across the phases that follow. All lanes use the same control word, but each lane computes and clamps on its own. The lane result is registered and appears one cycle after the strobe, together with the updated register state.

Top module: `simd_acc_unit`

## Requirements
- R1: After synchronous reset, every accumulator reads zero and `out_valid` is low.
- R2: `out_valid` rises in the cycle after `in_valid` is sampled high and is low otherwise. `lane_result` and `acc_state` show the outcome of that operation in the same cycle as `out_valid`.
- R3: With control bit 5 (enable) clear, each lane's result equals its input data, and the accumulator keeps its value.
- R4: With enable set, control bit 0 selects the arithmetic. 1 forms accumulator minus operand. 0 forms accumulator plus operand.
- R5: Control bit 3 selects how the 32-bit lane value is extended. 1 sign-extends it. 0 zero-extends it.
- R6: With control bit 4 set, the extended operand is shifted left 16 places before the arithmetic, and the lane result is bits 47:16 of the clamped value. With bit 4 clear, the operand is not shifted and the result is bits 31:0.
- R7: The arithmetic result is clamped to 0x7fffffffffff when it is above that value and to 0x800000000000 when it is below it. The clamped value is used both for the result and for writeback.
- R8: With enable and control bit 1 both set, the clamped value is stored in the accumulator. With bit 1 clear, no arithmetic result is stored.
- R9: When control bit 2 is set, enable is set and `first_phase` is high, the accumulator operand for that operation is zero. Without writeback, the register is left at zero. Bit 2 has no effect when `first_phase` is low.
- R10: Each lane computes and clamps from its own data and its own accumulator only.
- R11: When `in_valid` is low, no accumulator changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| first_phase | input | 1 | Marks the first phase of an instruction |
| ctrl | input | 6 | Control word {enable, high, signed, clear, writeback, subtract} |
| lane_data | input | 32*LANES | Lane ALU results; lane i is bits 32i+31:32i |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| lane_result | output | 32*LANES | Registered per-lane results |
| acc_state | output | 48*LANES | Accumulator registers; lane i is bits 48i+47:48i |

## Verification
The assertions assume that `ctrl`, `first_phase` and `lane_data` are stable and known at each clock edge where `in_valid` is high. They also assume that `rst` is not raised in the same cycle as an operation whose outcome they check. The bench drives all inputs on the falling edge and keeps reset low throughout its random phase. The random control words include the clear bit with `first_phase` both high and low, so that the assertions on clear and on holding the register see both cases. Operands are biased toward extreme magnitudes in high mode, so that clamping at both ends takes place within the run.

// File: rtl/simd_acc_pkg.sv
package simd_acc_pkg;

    localparam int DATA_W     = 32;
    localparam int ACC_W      = 48;
    localparam int HIGH_SHIFT = ACC_W - DATA_W;
    localparam int SUM_W      = ACC_W + 2;
    localparam int CTRL_W     = 6;

    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // Field order matches control bits 5 down to 0.
    typedef struct packed {
        logic ena;
        logic high;
        logic sgn;
        logic clr;
        logic wb;
        logic sub;
    } acc_ctrl_t;

    typedef struct packed {
        logic [ACC_W-1:0]  sat_val;
        logic [DATA_W-1:0] result;
        logic              store;
        logic [ACC_W-1:0]  store_val;
    } lane_out_t;

    // Extend the lane value to the wide intermediate width and align it.
    function automatic logic [SUM_W-1:0] widen_operand(
        input logic [DATA_W-1:0] data,
        input logic              sgn,
        input logic              high
    );
        logic [SUM_W-1:0] ext;
        if (sgn) begin
            ext = {{(SUM_W-DATA_W){data[DATA_W-1]}}, data};
        end else begin
            ext = {{(SUM_W-DATA_W){1'b0}}, data};
        end
        if (high) begin
            return ext << HIGH_SHIFT;
        end
        return ext;
    endfunction

    // Clamp the wide intermediate to the signed accumulator range.
    function automatic logic [ACC_W-1:0] clamp_sum(input logic [SUM_W-1:0] sum);
        logic [SUM_W-ACC_W:0] top;
        top = sum[SUM_W-1:ACC_W-1];
        if ((top == '0) || (top == '1)) begin
            return sum[ACC_W-1:0];
        end
        if (sum[SUM_W-1]) begin
            return ACC_MIN;
        end
        return ACC_MAX;
    endfunction

    function automatic logic [DATA_W-1:0] pick_window(
        input logic [ACC_W-1:0] val,
        input logic             high
    );
        if (high) begin
            return val[ACC_W-1:HIGH_SHIFT];
        end
        return val[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/acc_lane_math.sv
module acc_lane_math
    import simd_acc_pkg::*;
(
    input  logic [ACC_W-1:0]  acc_q,
    input  logic [DATA_W-1:0] data,
    input  acc_ctrl_t         op,
    input  logic              first_phase,
    output lane_out_t         res
);

    logic             clear_hit;
    logic [ACC_W-1:0] base;
    logic [SUM_W-1:0] base_w;
    logic [SUM_W-1:0] operand;
    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] sat;

    always_comb begin
        clear_hit = op.ena && op.clr && first_phase;
        base      = clear_hit ? '0 : acc_q;
        base_w    = {{(SUM_W-ACC_W){base[ACC_W-1]}}, base};
        operand   = widen_operand(data, op.sgn, op.high);
        sum       = op.sub ? (base_w - operand) : (base_w + operand);
        sat       = clamp_sum(sum);
    end

    always_comb begin
        res.sat_val = sat;
        if (op.ena) begin
            res.result = pick_window(sat, op.high);
        end else begin
            res.result = data;
        end
        res.store     = op.ena && (op.wb || clear_hit);
        res.store_val = op.wb ? sat : '0;
    end

endmodule

// File: rtl/acc_lane_reg.sv
module acc_lane_reg
    import simd_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  lane_out_t         res,
    output logic [ACC_W-1:0]  acc_q,
    output logic [DATA_W-1:0] result_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            result_q <= '0;
        end else if (fire) begin
            result_q <= res.result;
            if (res.store) begin
                acc_q <= res.store_val;
            end
        end
    end

endmodule

// File: rtl/simd_acc_unit.sv
module simd_acc_unit
    import simd_acc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    first_phase,
    input  logic [CTRL_W-1:0]       ctrl,
    input  logic [LANES*DATA_W-1:0] lane_data,
    output logic                    out_valid,
    output logic [LANES*DATA_W-1:0] lane_result,
    output logic [LANES*ACC_W-1:0]  acc_state
);

    acc_ctrl_t op;
    assign op = acc_ctrl_t'(ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_out_t         res;
        logic [ACC_W-1:0]  acc_q;
        logic [DATA_W-1:0] result_q;

        acc_lane_math i_math (
            .acc_q       (acc_q),
            .data        (lane_data[g*DATA_W +: DATA_W]),
            .op          (op),
            .first_phase (first_phase),
            .res         (res)
        );

        acc_lane_reg i_reg (
            .clk      (clk),
            .rst      (rst),
            .fire     (in_valid),
            .res      (res),
            .acc_q    (acc_q),
            .result_q (result_q)
        );

        assign acc_state[g*ACC_W +: ACC_W]      = acc_q;
        assign lane_result[g*DATA_W +: DATA_W] = result_q;
    end

endmodule

// File: rtl/simd_acc_chk.sv
module simd_acc_chk
    import simd_acc_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    first_phase,
    input logic [CTRL_W-1:0]       ctrl,
    input logic [LANES*DATA_W-1:0] lane_data,
    input logic                    out_valid,
    input logic [LANES*DATA_W-1:0] lane_result,
    input logic [LANES*ACC_W-1:0]  acc_state
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(acc_state));

    // R3
    bypass_data_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctrl[5]) |=> (lane_result == $past(lane_data)));

    // R3
    bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctrl[5]) |=> $stable(acc_state));

    // R8
    no_wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl[5] && !ctrl[1] && !(ctrl[2] && first_phase))
        |=> $stable(acc_state));

    // R9
    clear_only_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl[5] && !ctrl[1] && ctrl[2] && first_phase)
        |=> (acc_state == '0));

endmodule

bind simd_acc_unit simd_acc_chk #(.LANES(LANES)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .first_phase (first_phase),
    .ctrl        (ctrl),
    .lane_data   (lane_data),
    .out_valid   (out_valid),
    .lane_result (lane_result),
    .acc_state   (acc_state)
);

// File: tb/test_simd_acc_unit.sv
module test_simd_acc_unit;
    localparam int LANES = 4;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic                  first_phase = 1'b0;
    logic [5:0]            ctrl = '0;
    logic [LANES*32-1:0]   lane_data = '0;
    logic                  out_valid;
    logic [LANES*32-1:0]   lane_result;
    logic [LANES*48-1:0]   acc_state;

    int checks = 0;
    int errors = 0;
    longint model_acc [LANES];
    logic [31:0] model_res [LANES];
    logic model_valid;

    localparam longint MAXV = 64'sd140737488355327;
    localparam longint MINV = -64'sd140737488355328;

    always #4 clk = ~clk;

    simd_acc_unit #(.LANES(LANES)) i_simd_acc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .first_phase(first_phase),
        .ctrl(ctrl), .lane_data(lane_data), .out_valid(out_valid),
        .lane_result(lane_result), .acc_state(acc_state)
    );

    initial begin
        #1_600_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic longint to48(input longint v);
        logic [47:0] b;
        b = v[47:0];
        return longint'(signed'(b));
    endfunction

    // Reference per-lane step; fields: 5 ena, 4 high, 3 sgn, 2 clr, 1 wb, 0 sub
    task automatic model_step(input logic [5:0] c, input logic fp, input logic [LANES*32-1:0] d);
        for (int i = 0; i < LANES; i++) begin
            logic [31:0] x;
            longint op, base, s;
            x = d[i*32 +: 32];
            if (!c[5]) begin
                model_res[i] = x;
            end else begin
                op   = c[3] ? longint'(signed'(x)) : longint'({32'b0, x});
                if (c[4]) op = op * 65536;
                base = (c[2] && fp) ? 0 : model_acc[i];
                s    = c[0] ? base - op : base + op;
                if (s > MAXV) s = MAXV;
                if (s < MINV) s = MINV;
                model_res[i] = c[4] ? s[47:16] : s[31:0];
                if (c[1]) model_acc[i] = s;
                else if (c[2] && fp) model_acc[i] = 0;
            end
        end
    endtask

    task automatic check_outputs(input string tag);
        checks++;
        if (out_valid !== model_valid) begin
            errors++;
            $display("FAIL %s R2 out_valid actual %b expected %b", tag, out_valid, model_valid);
        end
        for (int i = 0; i < LANES; i++) begin
            longint a;
            a = to48(longint'({16'b0, acc_state[i*48 +: 48]}));
            checks++;
            if (a !== model_acc[i]) begin
                errors++;
                $display("FAIL %s lane %0d acc actual %h expected %h", tag, i,
                         acc_state[i*48 +: 48], model_acc[i][47:0]);
            end
            if (model_valid) begin
                checks++;
                if (lane_result[i*32 +: 32] !== model_res[i]) begin
                    errors++;
                    $display("FAIL %s lane %0d result actual %h expected %h", tag, i,
                             lane_result[i*32 +: 32], model_res[i]);
                end
            end
        end
    endtask

    task automatic step(input logic v, input logic fp, input logic [5:0] c,
                        input logic [LANES*32-1:0] d, input string tag);
        in_valid = v; first_phase = fp; ctrl = c; lane_data = d;
        @(posedge clk);
        model_valid = v;
        if (v) model_step(c, fp, d);
        @(negedge clk);
        check_outputs(tag);
    endtask

    function automatic logic [LANES*32-1:0] splat(input logic [31:0] x);
        return {LANES{x}};
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < LANES; i++) begin
            model_acc[i] = 0;
            model_res[i] = '0;
        end
        model_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_outputs("R1 reset");

        // R4 R5: unsigned accumulate, then signed decrement
        step(1, 1, 6'b100110, splat(32'd100), "R9 R4 clear+add");
        step(1, 0, 6'b100110, splat(32'd50), "R9 no clear later phase");
        step(1, 0, 6'b101011, splat(32'hFFFF_FFFF), "R5 R4 signed sub of -1");
        step(1, 0, 6'b100011, splat(32'h0000_0001), "R4 unsigned sub");
        step(1, 0, 6'b100010, splat(32'hFFFF_FFFF), "R5 unsigned extend");
        // R3 bypass
        step(1, 0, 6'b011111, {32'h1, 32'h2, 32'h3, 32'h4}, "R3 enable clear");
        // R11 idle
        step(0, 0, 6'b100010, splat(32'h7777), "R11 idle");
        // R8 no writeback
        step(1, 0, 6'b100000, splat(32'd5), "R8 no writeback");
        // R9 clear with no writeback
        step(1, 1, 6'b100100, splat(32'd9), "R9 clear only");
        // R6 R7 high mode saturation both ways
        step(1, 1, 6'b111110, splat(32'h7FFF_FFFF), "R6 high signed max");
        step(1, 0, 6'b110010, splat(32'hFFFF_FFFF), "R7 saturate top");
        step(1, 0, 6'b111000, splat(32'h0000_0001), "R7 R8 read-only at max");
        step(1, 1, 6'b111110, splat(32'h8000_0000), "R6 high signed min");
        step(1, 0, 6'b110011, splat(32'hFFFF_FFFF), "R7 saturate bottom");
        // R10 distinct lanes
        step(1, 1, 6'b101110, {32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 32'h12345678}, "R10 lanes");
        step(1, 0, 6'b111011, {32'h7FFF_FFFF, 32'h8000_0000, 32'h1, 32'hFFFF0000}, "R10 lanes high");

        for (int n = 0; n < 3000; n++) begin
            logic [5:0] c;
            logic [LANES*32-1:0] d;
            logic v, fp;
            v  = ($urandom % 4) != 0;
            fp = ($urandom % 5) == 0;
            c  = 6'($urandom);
            if (($urandom % 4) != 0) c[5] = 1'b1;
            for (int i = 0; i < LANES; i++) begin
                case ($urandom % 4)
                    0: d[i*32 +: 32] = 32'h7FFF_FFFF;
                    1: d[i*32 +: 32] = 32'h8000_0000 | ($urandom % 16);
                    2: d[i*32 +: 32] = $urandom % 1000;
                    default: d[i*32 +: 32] = $urandom;
                endcase
            end
            step(v, fp, c, d, "random R4 R5 R6 R7 R8 R9");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule